// File: doc/BRIEF.md
# Guarded Fixed-Point Multiply-Accumulate Unit

This block multiplies two operands and folds the product into a wide accumulator in a single clock cycle. Three operations can be selected: a plain multiply that replaces the accumulator contents, a multiply-add, and a multiply-subtract. The accumulator is wider than a full product by a set of guard bits. With the default sizes, 16-bit operands give a 32-bit product and the accumulator is 40 bits wide. This lets long sums run past the product range without losing the sign.

Each operand has its own signedness control. This allows the partial products of wider numbers to be combined in several passes, with an unsigned low word and a signed high word. An overflow flag reports when the accumulator no longer fits in a signed product-width value. A clamped product-width result is always available alongside the full accumulator.

Top module: `mac_guarded`

## Requirements
- R1: While `rst_n` is low, `acc` is zero, `overflow` is 0 and `sat_out` is zero.
- R2: With `valid`=1, `clear`=0 and `op_sel`=2'b00, the next `acc` is the product `op_a`×`op_b`, sign-extended to the accumulator width. Each operand is read as two's complement when its signed control (`a_signed`, `b_signed`) is 1, and as unsigned when it is 0.
- R3: With `op_sel`=2'b01 (and `valid`=1, `clear`=0), the product is added to the previous `acc`.
- R4: With `op_sel`=2'b10 (and `valid`=1, `clear`=0), the product is subtracted from the previous `acc`.
- R5: Accumulation wraps modulo 2^(2·DW+GW). No saturation is applied to `acc` itself.
- R6: `overflow` is 1 exactly when the top GW+1 bits of `acc` are not all equal. This means `acc` falls outside the signed 2·DW-bit range.
- R7: `sat_out` equals the low 2·DW bits of `acc` when `overflow` is 0. When `overflow` is 1, `sat_out` is the most positive 2·DW-bit value if `acc` is positive, and the most negative value if `acc` is negative.
- R8: `clear`=1 sets `acc` to zero on the next edge. This happens whatever the values of `valid` and `op_sel`.
- R9: With `valid`=0 and `clear`=0, `acc` keeps its value, even when the operands change.
- R10: `op_sel`=2'b11 is reserved. With `valid`=1 and `clear`=0 it leaves `acc` unchanged.
- R11: Each operation's result appears on `acc` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | DW | First operand |
| op_b | input | DW | Second operand |
| a_signed | input | 1 | 1: `op_a` is two's complement |
| b_signed | input | 1 | 1: `op_b` is two's complement |
| op_sel | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 reserved |
| clear | input | 1 | Synchronous accumulator clear, highest priority |
| valid | input | 1 | Operation strobe |
| acc | output | 2·DW+GW | Full accumulator |
| overflow | output | 1 | Accumulator outside signed 2·DW-bit range |
| sat_out | output | 2·DW | Clamped 2·DW-bit result |

## Verification
The hardest states to reach are the wrap of the guard bits and overflow in both directions. The default 40-bit accumulator needs hundreds of large products to leave its range. The bench therefore elaborates the unit with 4-bit operands and 2 guard bits. It then sweeps every operand pair under every signedness combination and every operation, without clearing between pairs. The running sums cross the overflow threshold and wrap around the accumulator many times, and the bench compares each step against an integer model.

// File: rtl/mac_guarded.sv
module mac_guarded #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        op_a,
  input  logic [DW-1:0]        op_b,
  input  logic                 a_signed,
  input  logic                 b_signed,
  input  logic [1:0]           op_sel,
  input  logic                 clear,
  input  logic                 valid,
  output logic [2*DW+GW-1:0]   acc,
  output logic                 overflow,
  output logic [2*DW-1:0]      sat_out
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;

  logic signed [DW:0]     a_ext, b_ext;
  logic signed [PW+1:0]   prod_full;
  logic        [AW-1:0]   prod, acc_nx;
  logic        [GW:0]     top;

  assign a_ext     = {a_signed & op_a[DW-1], op_a};
  assign b_ext     = {b_signed & op_b[DW-1], op_b};
  assign prod_full = a_ext * b_ext;
  assign prod      = {{(AW-PW-2){prod_full[PW+1]}}, prod_full};

  always_comb begin
    acc_nx = acc;
    if (clear) acc_nx = '0;
    else if (valid) begin
      case (op_sel)
        2'b00:   acc_nx = prod;
        2'b01:   acc_nx = acc + prod;
        2'b10:   acc_nx = acc - prod;
        default: acc_nx = acc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc <= '0;
    else        acc <= acc_nx;

  assign top      = acc[AW-1:PW-1];
  assign overflow = (|top) & ~(&top);
  assign sat_out  = !overflow      ? acc[PW-1:0] :
                    acc[AW-1]      ? {1'b1, {(PW-1){1'b0}}} :
                                     {1'b0, {(PW-1){1'b1}}};
endmodule

module mac_guarded_chk #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         op_sel,
  input logic               clear,
  input logic               valid,
  input logic [2*DW+GW-1:0] acc,
  input logic               overflow,
  input logic [2*DW-1:0]    sat_out
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !valid) |=> $stable(acc)); // R9
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && valid && op_sel == 2'b11) |=> $stable(acc)); // R10
  AST_SAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |-> sat_out == acc[PW-1:0]); // R7
  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (sat_out[PW-1] == acc[AW-1]) && ($countones(sat_out[PW-2:0]) == (acc[AW-1] ? 0 : PW-1))); // R7
  AST_NO_OVERFLOW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc[AW-1:PW-1] == '0) |-> !overflow); // R6
endmodule

bind mac_guarded mac_guarded_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .clear(clear), .valid(valid),
  .acc(acc), .overflow(overflow), .sat_out(sat_out)
);

// File: tb/mac_guarded_test.sv
module mac_guarded_test;
  localparam int DW = 4;
  localparam int GW = 2;
  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;
  localparam int AMOD = 1 << AW;
  localparam int PMAX = (1 << (PW - 1)) - 1;
  localparam int PMIN = -(1 << (PW - 1));

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] op_a = '0, op_b = '0;
  logic a_signed = 0, b_signed = 0, clear = 0, valid = 0;
  logic [1:0] op_sel = '0;
  logic [AW-1:0] acc;
  logic overflow;
  logic [PW-1:0] sat_out;

  int checks = 0, fails = 0, model = 0;
  bit wrapped;

  always #2.5 clk = ~clk;

  mac_guarded #(.DW(DW), .GW(GW)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .a_signed(a_signed),
    .b_signed(b_signed), .op_sel(op_sel), .clear(clear), .valid(valid),
    .acc(acc), .overflow(overflow), .sat_out(sat_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int opval(int v, bit s);
    return (s && v >= (1 << (DW - 1))) ? v - (1 << DW) : v;
  endfunction

  task automatic check_outputs(string req);
    int a, s;
    bit ovf;
    a = $signed(acc);
    s = $signed(sat_out);
    ovf = (model > PMAX) || (model < PMIN);
    check(req, a, model);
    check("R6", int'(overflow), int'(ovf));
    check("R7", s, ovf ? (model > 0 ? PMAX : PMIN) : model);
  endtask

  task automatic step(int a, int b, bit as, bit bs, int op, bit clr, bit vld);
    int p, raw;
    op_a = DW'(a); op_b = DW'(b); a_signed = as; b_signed = bs;
    op_sel = 2'(op); clear = clr; valid = vld;
    p = opval(a, as) * opval(b, bs);
    raw = model;
    if (clr) raw = 0;
    else if (vld) begin
      if (op == 0) raw = p;
      else if (op == 1) raw = model + p;
      else if (op == 2) raw = model - p;
    end
    model = ((raw % AMOD) + AMOD) % AMOD;
    if (model >= AMOD / 2) model -= AMOD;
    wrapped = (model != raw);
    @(posedge clk);
    #1; // R11: result visible right after one edge
  endtask

  initial begin
    #1;
    check("R1", int'(acc), 0);
    check("R1", int'(overflow), 0);
    check("R1", int'(sat_out), 0);
    #10 rst_n = 1;
    @(posedge clk); #1;

    for (int sm = 0; sm < 4; sm++)
      for (int op = 0; op < 3; op++) begin
        step(0, 0, 0, 0, 0, 1, 0);
        check_outputs("R8");
        for (int a = 0; a < (1 << DW); a++)
          for (int b = 0; b < (1 << DW); b++) begin
            step(a, b, sm[1], sm[0], op, 0, 1);
            if (wrapped) check_outputs("R5");
            else check_outputs(op == 0 ? "R2" : op == 1 ? "R3" : "R4");
          end
      end

    step(0, 0, 0, 0, 0, 1, 0);
    step(7, 7, 1, 1, 0, 0, 1);
    check_outputs("R2");
    step(15, 15, 0, 0, 1, 1, 1);
    check_outputs("R8");
    step(5, 6, 0, 0, 0, 0, 1);
    step(15, 15, 0, 0, 1, 0, 0);
    check_outputs("R9");
    step(3, 9, 1, 0, 2, 0, 0);
    check_outputs("R9");
    step(15, 15, 0, 0, 3, 0, 1);
    check_outputs("R10");
    step(8, 8, 1, 1, 3, 0, 1);
    check_outputs("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule